// File: doc/BRIEF.md
# Fall-Through FIFO with Strobe/Flag Handshake

This block is a first-in first-out store, 4 bits wide and 64 words deep, that works on one clock. It has no read or write pointer at its edge. A writer raises a level-sensitive shift-in strobe while the input-ready flag is high. The word is captured, and when the strobe falls the word moves on by itself toward the output. The oldest stored word therefore always waits in the output stage. A reader sees the output-ready flag, takes the word, and retires it on the falling edge of its shift-out strobe.

The flags can be wired directly between copies. For more depth, one copy's output word and output-ready flag drive the next copy's data input and shift-in strobe, and the next copy's input-ready flag drives the first copy's shift-out strobe. For more width, the AND of the copies' flags serves as the composite flag. A synchronous master reset empties the store. An output-enable input qualifies the output word in place of a three-state driver.

Top module: `fth_fifo`

## Requirements
- R1: While master reset is high at a clock edge, all stored words are discarded. After that edge, input-ready is 1 and output-ready is 0, and output-ready stays 0 until a new word is written.
- R2: At a clock edge where input-ready and shift-in are both 1, the data input is captured and input-ready reads 0 after that edge. Input-ready stays 0 while shift-in stays high.
- R3: The first clock edge at which shift-in is seen low after a capture releases the word. If there is room, input-ready returns to 1 within 3 clocks of that edge.
- R4: A word written into an empty store reaches the output stage with no read strobe. Output-ready goes to 1 within 6 clocks of the shift-in falling edge.
- R5: While output-ready is 1, the output holds the oldest unread word. A clock edge that sees shift-out go from 1 to 0 while output-ready is 1 retires that word, and output-ready reads 0 after that edge.
- R6: Words leave in exactly the order they were written, across any number of wraps of the internal storage.
- R7: The store holds exactly 64 words. Once 64 words are held without a read, input-ready stays 0, and a shift-in strobe given then neither adds a word nor changes a stored word.
- R8: When a word is read from a full store, input-ready returns to 1 within 8 clocks of the retiring edge.
- R9: A shift-out strobe given while output-ready is 0 is ignored. Output-ready stays 0 and no later word is lost.
- R10: The output-valid qualifier equals output-enable AND output-ready.
- R11: Two copies chained in depth, with Q to D, output-ready to shift-in and input-ready to shift-out, pass every word from the first copy's input to the second copy's output in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mr | input | 1 | Master reset, synchronous, active high |
| d_in | input | 4 | Data word to write |
| shift_in | input | 1 | Level-sensitive write strobe |
| in_ready | output | 1 | Input stage empty and able to accept a word |
| shift_out | input | 1 | Read strobe; its falling edge retires the output word |
| out_ready | output | 1 | Output stage holds a valid word |
| q_out | output | 4 | Oldest stored word |
| out_en | input | 1 | Output enable |
| q_valid | output | 1 | Output enable AND output-ready |

## Verification
A wrong pointer or count inside the store shows at the ports as a word read out of order, a repeated word, or a missing word. The scoreboard sees this on the very next read after the fault. A lost-word fault appears as output-ready staying low for longer than the fall-through bound. A stuck input stage or a wrong room calculation shows up as input-ready failing to return within its bound after a strobe or a read. When the store is full, the same fault shows as the flag rising before 64 words are held.

// File: rtl/fth_pkg.sv
package fth_pkg;
  // Address width of at least one bit for a store of n entries.
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned count_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fth_in_stage.sv
module fth_in_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         si,
  input  logic [W-1:0] din,
  input  logic         room,
  output logic         ready,
  output logic         push,
  output logic [W-1:0] push_data
);
  logic         held;
  logic         released;
  logic         si_q;
  logic [W-1:0] word;
  logic         si_fall;
  logic         capture;

  assign si_fall   = si_q & ~si;
  assign capture   = si & ~held;
  assign push      = held & released & room;
  assign push_data = word;
  assign ready     = ~held;

  always_ff @(posedge clk) begin
    if (rst) begin
      si_q     <= 1'b0;
      held     <= 1'b0;
      released <= 1'b0;
      word     <= '0;
    end else begin
      si_q <= si;
      if (capture) begin
        held     <= 1'b1;
        released <= 1'b0;
        word     <= din;
      end else if (push) begin
        held     <= 1'b0;
        released <= 1'b0;
      end else if (held && si_fall) begin
        released <= 1'b1;
      end
    end
  end

  // R2: a capture blocks further input on the next cycle
  a_r2_capture_blocks: assert property (@(posedge clk) disable iff (rst)
    (si && ready) |=> !ready);

  // R2: while the strobe stays high after a capture, the stage stays busy
  a_r2_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    (!ready && !released && si) |=> !ready);
endmodule

// File: rtl/fth_store.sv
module fth_store #(
  parameter int unsigned W         = 4,
  parameter int unsigned MEM_DEPTH = 62
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         room,
  output logic         nonempty
);
  import fth_pkg::*;
  localparam int unsigned AW = addr_bits(MEM_DEPTH);
  localparam int unsigned CW = count_bits(MEM_DEPTH);
  localparam logic [AW-1:0] LAST = AW'(MEM_DEPTH - 1);

  logic [W-1:0]  mem [MEM_DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;

  assign room     = (count < CW'(MEM_DEPTH));
  assign nonempty = (count != '0);

  // Storage array without reset so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // Registered read port: this register is the output stage.
  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a write is never accepted into a full store
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(MEM_DEPTH)));

  // R6: a fetch never reads an empty store
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

  // R7: occupancy stays within the storage size
  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(MEM_DEPTH));
endmodule

// File: rtl/fth_out_stage.sv
module fth_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic so,
  input  logic nonempty,
  output logic pop,
  output logic valid
);
  logic so_q;
  logic retire;

  assign retire = so_q & ~so & valid;
  assign pop    = ~valid & nonempty;

  always_ff @(posedge clk) begin
    if (rst) begin
      so_q  <= 1'b0;
      valid <= 1'b0;
    end else begin
      so_q <= so;
      if (retire)   valid <= 1'b0;
      else if (pop) valid <= 1'b1;
    end
  end

  // R5: a falling read strobe on a valid word empties the output stage
  a_r5_retire_clears: assert property (@(posedge clk) disable iff (rst)
    (so_q && !so && valid) |=> !valid);

  // R9: with nothing stored behind it, an empty output stage stays empty
  a_r9_empty_stays: assert property (@(posedge clk) disable iff (rst)
    (!valid && !nonempty) |=> !valid);
endmodule

// File: rtl/fth_fifo.sv
module fth_fifo #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         mr,
  input  logic [W-1:0] d_in,
  input  logic         shift_in,
  output logic         in_ready,
  input  logic         shift_out,
  output logic         out_ready,
  output logic [W-1:0] q_out,
  input  logic         out_en,
  output logic         q_valid
);
  // One word sits in the input stage, one in the output stage.
  localparam int unsigned MEM_DEPTH = DEPTH - 2;

  logic         push;
  logic [W-1:0] push_data;
  logic         room;
  logic         pop;
  logic         nonempty;
  logic         valid;

  fth_in_stage #(.W(W)) u_in (
    .clk       (clk),
    .rst       (mr),
    .si        (shift_in),
    .din       (d_in),
    .room      (room),
    .ready     (in_ready),
    .push      (push),
    .push_data (push_data)
  );

  fth_store #(.W(W), .MEM_DEPTH(MEM_DEPTH)) u_store (
    .clk       (clk),
    .rst       (mr),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .rd_data   (q_out),
    .room      (room),
    .nonempty  (nonempty)
  );

  fth_out_stage u_out (
    .clk      (clk),
    .rst      (mr),
    .so       (shift_out),
    .nonempty (nonempty),
    .pop      (pop),
    .valid    (valid)
  );

  assign out_ready = valid;
  assign q_valid   = out_en & valid;

  // R1: flags are in their empty state right after reset
  a_r1_reset_flags: assert property (@(posedge clk) disable iff (mr)
    $past(mr) |-> (in_ready && !out_ready));

  // R10: the qualifier follows enable and output-ready
  a_r10_qualifier: assert property (@(posedge clk) disable iff (mr)
    q_valid == (out_en && out_ready));
endmodule

// File: tb/fth_fifo_tb.sv
module fth_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 150000;

  logic       clk = 1'b0;
  logic       mr;
  logic [3:0] d_in;
  logic       shift_in;
  logic       in_ready;
  logic       shift_out;
  logic       out_ready;
  logic [3:0] q_out;
  logic       out_en;
  logic       q_valid;

  // cascade pair
  logic [3:0] ca_d;
  logic       ca_si;
  logic       ca_ir;
  logic       ca_or;
  logic [3:0] ca_q;
  logic       link_so;
  logic       cb_or;
  logic       cb_so;
  logic [3:0] cb_q;
  logic       cb_ir;
  logic       ca_qv;
  logic       cb_qv;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [3:0] expq[$];
  logic [3:0] casq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fth_fifo u_dut (
    .clk(clk), .mr(mr), .d_in(d_in), .shift_in(shift_in), .in_ready(in_ready),
    .shift_out(shift_out), .out_ready(out_ready), .q_out(q_out),
    .out_en(out_en), .q_valid(q_valid)
  );

  fth_fifo u_casc_a (
    .clk(clk), .mr(mr), .d_in(ca_d), .shift_in(ca_si), .in_ready(ca_ir),
    .shift_out(link_so), .out_ready(ca_or), .q_out(ca_q),
    .out_en(1'b1), .q_valid(ca_qv)
  );

  fth_fifo u_casc_b (
    .clk(clk), .mr(mr), .d_in(ca_q), .shift_in(ca_or), .in_ready(cb_ir),
    .shift_out(cb_so), .out_ready(cb_or), .q_out(cb_q),
    .out_en(1'b1), .q_valid(cb_qv)
  );

  assign link_so = cb_ir;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, LIMIT);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: writes one word and records it in the scoreboard.
  task automatic put(input logic [3:0] v);
    int t = 0;
    while (!in_ready && t < 2000) begin @(negedge clk); t++; end
    d_in = v; shift_in = 1'b1;
    @(negedge clk);
    chk("R2 ready low after capture", int'(in_ready), 0);
    expq.push_back(v);
    tick(1);
    chk("R2 ready held while strobe high", int'(in_ready), 0);
    shift_in = 1'b0;
    begin
      int k = 0;
      while (!in_ready && k < 3) begin @(negedge clk); k++; end
    end
    if (expq.size() < 64) chk("R3 ready returns", int'(in_ready), 1);
  endtask

  // Monitor: waits for output data, compares against the scoreboard.
  task automatic get(input string req);
    int t = 0;
    logic [3:0] e;
    while (!out_ready && t < 2000) begin @(negedge clk); t++; end
    e = (expq.size() != 0) ? expq.pop_front() : 4'hx;
    chk(req, int'(q_out), int'(e));
    shift_out = 1'b1;
    @(negedge clk);
    shift_out = 1'b0;
    @(negedge clk);
    chk("R5 output-ready low after retire", int'(out_ready), 0);
  endtask

  task automatic do_reset();
    mr = 1'b1; tick(2); mr = 1'b0; tick(1);
    expq.delete(); casq.delete();
  endtask

  initial begin
    mr = 1'b1; d_in = '0; shift_in = 1'b0; shift_out = 1'b0; out_en = 1'b1;
    ca_d = '0; ca_si = 1'b0; cb_so = 1'b0;
    tick(3); mr = 1'b0; tick(1);

    // R1 reset state
    chk("R1 input-ready after reset", int'(in_ready), 1);
    chk("R1 output-ready after reset", int'(out_ready), 0);

    // R9 read strobe on an empty output stage
    shift_out = 1'b1; tick(2); shift_out = 1'b0; tick(3);
    chk("R9 empty read ignored", int'(out_ready), 0);

    // R4 fall-through bound
    d_in = 4'hA; shift_in = 1'b1; tick(1); shift_in = 1'b0; expq.push_back(4'hA);
    begin
      int k = 0;
      while (!out_ready && k < 6) begin @(negedge clk); k++; end
    end
    chk("R4 fall-through to output", int'(out_ready), 1);
    chk("R4 word at output", int'(q_out), 4'hA);

    // R10 qualifier
    out_en = 1'b0; #1;
    chk("R10 qualifier with enable low", int'(q_valid), 0);
    out_en = 1'b1; #1;
    chk("R10 qualifier with enable high", int'(q_valid), 1);
    tick(1);
    get("R5 oldest word");

    // R9 then order after ignored read
    put(4'h3); put(4'hC);
    get("R9 no word lost"); get("R9 second word");

    // R6 alternating patterns and wrap-around
    for (int i = 0; i < 40; i++) begin
      put(4'(i)); put(4'(i ^ 5)); put(4'(~i));
      get("R6 order 0"); get("R6 order 1"); get("R6 order 2");
    end

    // R1 reset mid-stream
    put(4'h1); put(4'h2); put(4'h4);
    mr = 1'b1; tick(2); mr = 1'b0; tick(1);
    expq.delete();
    chk("R1 ready after mid-stream reset", int'(in_ready), 1);
    tick(6);
    chk("R1 contents discarded", int'(out_ready), 0);

    // R7 capacity
    for (int i = 0; i < 64; i++) put(4'(i * 7));
    tick(6);
    chk("R7 full after 64 words", int'(in_ready), 0);
    d_in = 4'hF; shift_in = 1'b1; tick(3);
    chk("R7 write ignored while full", int'(in_ready), 0);
    shift_in = 1'b0; tick(2);

    // R8 room after a read from full
    get("R8 first of full store");
    begin
      int k = 0;
      while (!in_ready && k < 8) begin @(negedge clk); k++; end
    end
    chk("R8 ready returns after read", int'(in_ready), 1);
    for (int i = 0; i < 63; i++) get("R7 stored word intact");
    tick(8);
    chk("R7 ignored write added nothing", int'(out_ready), 0);

    // R11 cascade in depth
    do_reset();
    for (int i = 0; i < 12; i++) begin
      int t = 0;
      while (!ca_ir && t < 2000) begin @(negedge clk); t++; end
      ca_d = 4'(i * 3 + 1); ca_si = 1'b1; casq.push_back(4'(i * 3 + 1));
      tick(1); ca_si = 1'b0; tick(1);
    end
    tick(20);
    for (int i = 0; i < 12; i++) begin
      int t = 0;
      logic [3:0] e;
      while (!cb_or && t < 2000) begin @(negedge clk); t++; end
      e = casq.pop_front();
      chk("R11 cascade order", int'(cb_q), int'(e));
      cb_so = 1'b1; tick(1); cb_so = 1'b0; tick(2);
    end
    tick(10);
    chk("R11 cascade drained", int'(cb_or), 0);

    report();
  end
endmodule